// File: doc/BRIEF.md
# Iterative Double-Precision Floating-Point Divider

This block divides one 64-bit binary floating-point operand by another, in the standard double format: 1 sign bit, 11 exponent bits with bias 1023, 52 fraction bits. A one-cycle `start` pulse captures both operands. The block then splits each word into sign, exponent and significand. The result sign and exponent are formed directly. The significands are divided by a restoring shift-and-subtract loop that produces one quotient bit per clock. The quotient is normalized, rounded to nearest-even and repacked. After a fixed number of cycles a one-cycle `done` pulse marks `quot` as valid.

A separate selection stage handles the exceptional operands and results: NaNs, infinities, zeros, division by zero, exponent overflow and exponent underflow. When the operand pair is exceptional, the recurrence is held idle. Subnormal operands and subnormal results are flushed to signed zero. Every operation, including the exceptional ones, takes the same fixed latency, so the issuing logic can schedule the result without watching the data.

Top module: `fdiv64_iter`

## Requirements
- R1: Every non-NaN result carries the sign `opa[63] XOR opb[63]`.
- R2: For normal operands whose quotient is normal, `quot` equals the exact quotient rounded to nearest, ties to even. Its biased exponent is `ea - eb + 1023`, minus one when the significand quotient is below 1, plus one when rounding carries out of the significand.
- R3: `done` is high for exactly one cycle, on the 58th rising edge after the edge that accepted `start`. `quot` then holds its value until the next `done`.
- R4: A `start` that arrives while an operation is in flight is ignored. It causes no extra `done`, and it does not change the result of the operation in flight.
- R5: A signaling NaN (exponent all ones, fraction bit 51 = 0, fraction nonzero) in either operand takes priority over any quiet NaN. The result is that operand with fraction bit 51 set to 1. Operand A is chosen when both operands are signaling NaNs.
- R6: A quiet NaN (exponent all ones, fraction bit 51 = 1) is returned unchanged when no signaling NaN is present. Operand A's NaN is returned when both operands are quiet NaNs.
- R7: 0/0 and inf/inf return the default NaN `64'h7FF8_0000_0000_0000`.
- R8: A finite nonzero value divided by zero, or infinity divided by a finite value, returns infinity with the R1 sign.
- R9: Zero divided by a nonzero finite value, or a finite value divided by infinity, returns zero with the R1 sign.
- R10: A rounded biased exponent of 2047 or more gives signed infinity. A rounded biased exponent of 0 or less gives signed zero.
- R11: An operand with exponent field 0 is treated as a zero of its own sign, whatever its fraction.
- R12: While `rst_n` is low at a clock edge, `done` and `quot` are cleared and any operation in flight is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a division; only sampled while the block is idle |
| opa | input | 64 | Dividend, double format |
| opb | input | 64 | Divisor, double format |
| done | output | 1 | One-cycle pulse: `quot` is valid |
| quot | output | 64 | Quotient, double format |

## Verification
The embedded properties assume the following about the inputs:
- `opa` and `opb` are defined whenever `start` is sampled high.
- `start` is a level sampled at the clock edge.
- Between captures, the captured operands change only through a new accepted `start`.

The remainder-bound and quotient-MSB properties additionally assume that the recurrence runs only on two normal significands. The block guarantees this by gating the loop with the operand classification.

The stimulus changes inputs only on falling edges and reads results there. Its operand pairs avoid quotients that land within rounding distance of the smallest normal, where flush-to-zero and gradual underflow would disagree.

// File: rtl/fdiv64_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the operand classification record for the
// double-precision divider. Assumes the standard 1/11/52 layout.
package fdiv64_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;           // hidden one plus fraction
    localparam int QUO_W  = FRAC_W + 3;           // integer bit, fraction, guard
    localparam int EXPS_W = EXP_W + 2;            // signed working exponent
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int QBIT   = FRAC_W - 1;           // quiet-NaN marker bit

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic              is_zero;
        logic              is_inf;
        logic              is_nan;
        logic              is_snan;
    } fp_class_t;
endpackage

// File: rtl/fdiv64_classify.sv
`timescale 1ns/1ps
// Module: fdiv64_classify
// Splits one double word into fields and flags its class. A zero exponent
// field is flushed to zero regardless of fraction (subnormals are not kept).
// Purely combinational.
module fdiv64_classify
    import fdiv64_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_class_t         cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;

    // Field extraction and class decode
    always_comb begin
        exp_f    = word[WORD_W-2 -: EXP_W];
        frac_f   = word[FRAC_W-1:0];
        exp_ones = &exp_f;
        cls.sign    = word[WORD_W-1];
        cls.exp     = exp_f;
        cls.is_zero = (exp_f == '0);
        cls.is_inf  = exp_ones && (frac_f == '0);
        cls.is_nan  = exp_ones && (frac_f != '0);
        cls.is_snan = exp_ones && (frac_f != '0) && !frac_f[QBIT];
        cls.mant    = cls.is_zero ? '0 : {1'b1, frac_f};
    end
endmodule

// File: rtl/fdiv64_recur.sv
`timescale 1ns/1ps
// Module: fdiv64_recur
// Restoring significand division, one quotient bit per enabled cycle, MSB
// first. Assumes load precedes step and that divisor has its top bit set
// when stepping (the caller gates step on normal operands).
module fdiv64_recur
    import fdiv64_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [MANT_W-1:0] dividend,
    input  logic [MANT_W-1:0] divisor,
    output logic [QUO_W-1:0]  quo,
    output logic              rem_nz
);
    localparam int REM_W = MANT_W + 2;

    logic [REM_W-1:0]  rem;
    logic [REM_W-1:0]  rem_sub;
    logic [REM_W-1:0]  rem_nx;
    logic [MANT_W-1:0] dvsr_q;
    logic              ge;

    // One trial subtraction and shift of the partial remainder
    always_comb begin
        ge      = rem >= {2'b00, dvsr_q};
        rem_sub = ge ? (rem - {2'b00, dvsr_q}) : rem;
        rem_nx  = {rem_sub[REM_W-2:0], 1'b0};
        rem_nz  = (rem != '0);
    end

    // Remainder, divisor and quotient registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            dvsr_q <= '0;
            quo    <= '0;
        end else if (load) begin
            rem    <= {2'b00, dividend};
            dvsr_q <= divisor;
            quo    <= '0;
        end else if (step) begin
            rem    <= rem_nx;
            quo    <= {quo[QUO_W-2:0], ge};
        end
    end

    // R2: restoring invariant, partial remainder stays below twice the divisor
    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvsr_q[MANT_W-1]) |-> (rem < {1'b0, dvsr_q, 1'b0}));
endmodule

// File: rtl/fdiv64_round.sv
`timescale 1ns/1ps
// Module: fdiv64_round
// Normalizes the raw quotient (at most one left shift, since it lies in
// (0.5, 2)), rounds to nearest-even using guard and sticky, and adjusts the
// working exponent. Combinational.
module fdiv64_round
    import fdiv64_pkg::*;
(
    input  logic [QUO_W-1:0]         quo,
    input  logic                     rem_nz,
    input  logic signed [EXPS_W-1:0] exp_in,
    output logic signed [EXPS_W-1:0] exp_out,
    output logic [FRAC_W-1:0]        frac_out
);
    logic              norm;
    logic [MANT_W-1:0] sig;
    logic              guard;
    logic              sticky;
    logic              inc;
    logic [MANT_W:0]   sum;
    logic              carry;

    // Normalize, round, and fold the carry back into the exponent
    always_comb begin
        norm     = quo[QUO_W-1];
        sig      = norm ? quo[QUO_W-1:2] : quo[QUO_W-2:1];
        guard    = norm ? quo[1] : quo[0];
        sticky   = norm ? (quo[0] | rem_nz) : rem_nz;
        inc      = guard & (sticky | sig[0]);
        sum      = {1'b0, sig} + {{MANT_W{1'b0}}, inc};
        carry    = sum[MANT_W];
        frac_out = carry ? '0 : sum[FRAC_W-1:0];
        exp_out  = exp_in + EXPS_W'(carry) - EXPS_W'(!norm);
    end
endmodule

// File: rtl/fdiv64_special.sv
`timescale 1ns/1ps
// Module: fdiv64_special
// Chooses the final word: NaN propagation (signaling before quiet, A before
// B), invalid operations, infinities, zeros, and exponent overflow and
// underflow of the rounded path. Combinational.
module fdiv64_special
    import fdiv64_pkg::*;
(
    input  fp_class_t                ca,
    input  fp_class_t                cb,
    input  logic [WORD_W-1:0]        a_word,
    input  logic [WORD_W-1:0]        b_word,
    input  logic signed [EXPS_W-1:0] exp_r,
    input  logic [FRAC_W-1:0]        frac_r,
    output logic [WORD_W-1:0]        res
);
    localparam logic signed [EXPS_W-1:0] EXP_TOP  = EXPS_W'(EXP_MAX);
    localparam logic signed [EXPS_W-1:0] EXP_ZERO = '0;
    localparam logic [WORD_W-1:0] QMASK   = WORD_W'(1) << QBIT;
    localparam logic [WORD_W-1:0] NAN_DEF = {1'b0, {EXP_W{1'b1}}, QMASK[FRAC_W-1:0]};

    logic sgn;

    // Priority selection of the result word
    always_comb begin
        sgn = ca.sign ^ cb.sign;
        if (ca.is_snan)                                  res = a_word | QMASK;
        else if (cb.is_snan)                             res = b_word | QMASK;
        else if (ca.is_nan)                              res = a_word;
        else if (cb.is_nan)                              res = b_word;
        else if ((ca.is_zero && cb.is_zero) ||
                 (ca.is_inf && cb.is_inf))               res = NAN_DEF;
        else if (ca.is_inf || cb.is_zero)                res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (ca.is_zero || cb.is_inf)                res = {sgn, {(WORD_W-1){1'b0}}};
        else if (exp_r >= EXP_TOP)                       res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (exp_r <= EXP_ZERO)                      res = {sgn, {(WORD_W-1){1'b0}}};
        else                                             res = {sgn, exp_r[EXP_W-1:0], frac_r};
    end
endmodule

// File: rtl/fdiv64_iter.sv
`timescale 1ns/1ps
// Module: fdiv64_iter (top)
// Sequences one division: capture, load, QUO_W recurrence steps, round,
// pack. Fixed latency for every operand pair; the recurrence is gated off
// when either operand is not a normal number. start is ignored while busy.
module fdiv64_iter
    import fdiv64_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              done,
    output logic [WORD_W-1:0] quot
);
    localparam int NOPS  = 2;
    localparam int CNT_W = $clog2(QUO_W);

    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ITER, S_RND, S_PACK} st_t;

    st_t                      state;
    logic [CNT_W-1:0]         cnt;
    logic [WORD_W-1:0]        op_q [NOPS];
    fp_class_t                cls  [NOPS];
    logic                     ops_normal;
    logic signed [EXPS_W-1:0] exp_pre;
    logic signed [EXPS_W-1:0] exp_pre_q;
    logic signed [EXPS_W-1:0] rnd_exp;
    logic signed [EXPS_W-1:0] exp_r;
    logic [FRAC_W-1:0]        rnd_frac;
    logic [FRAC_W-1:0]        frac_r;
    logic [QUO_W-1:0]         rec_quo;
    logic                     rec_rem_nz;
    logic [WORD_W-1:0]        spec_res;

    // One classifier per captured operand
    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fdiv64_classify u_cls (.word(op_q[g]), .cls(cls[g]));
    end

    // Gate and unbiased-then-rebiased exponent difference
    always_comb begin
        ops_normal = !(cls[0].is_zero || cls[0].is_inf || cls[0].is_nan ||
                       cls[1].is_zero || cls[1].is_inf || cls[1].is_nan);
        exp_pre    = $signed({2'b00, cls[0].exp}) - $signed({2'b00, cls[1].exp})
                     + EXPS_W'(BIAS);
    end

    fdiv64_recur u_recur (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == S_LOAD && ops_normal),
        .step     (state == S_ITER && ops_normal),
        .dividend (cls[0].mant),
        .divisor  (cls[1].mant),
        .quo      (rec_quo),
        .rem_nz   (rec_rem_nz)
    );

    fdiv64_round u_round (
        .quo      (rec_quo),
        .rem_nz   (rec_rem_nz),
        .exp_in   (exp_pre_q),
        .exp_out  (rnd_exp),
        .frac_out (rnd_frac)
    );

    fdiv64_special u_special (
        .ca     (cls[0]),
        .cb     (cls[1]),
        .a_word (op_q[0]),
        .b_word (op_q[1]),
        .exp_r  (exp_r),
        .frac_r (frac_r),
        .res    (spec_res)
    );

    // Sequencer, operand capture and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            done      <= 1'b0;
            quot      <= '0;
            exp_pre_q <= '0;
            exp_r     <= '0;
            frac_r    <= '0;
            for (int i = 0; i < NOPS; i++) op_q[i] <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    op_q[0] <= opa;
                    op_q[1] <= opb;
                    state   <= S_LOAD;
                end
                S_LOAD: begin
                    exp_pre_q <= exp_pre;
                    cnt       <= '0;
                    state     <= S_ITER;
                end
                S_ITER: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(QUO_W - 1)) state <= S_RND;
                end
                S_RND: begin
                    exp_r  <= rnd_exp;
                    frac_r <= rnd_frac;
                    state  <= S_PACK;
                end
                S_PACK: begin
                    quot  <= spec_res;
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: captured operands cannot change while an operation is in flight
    a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(op_q[0]) && $stable(op_q[1])));

    // R2: the raw quotient of two normal significands has one of its top two bits set
    a_r2_quo_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RND && ops_normal) |-> (rec_quo[QUO_W-1] || rec_quo[QUO_W-2]));

    // R1: non-NaN results carry the XOR of the operand signs
    a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !((&quot[WORD_W-2 -: EXP_W]) && (quot[FRAC_W-1:0] != '0)))
        |-> (quot[WORD_W-1] == (op_q[0][WORD_W-1] ^ op_q[1][WORD_W-1])));

    // R6: any NaN operand yields a quiet NaN
    a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cls[0].is_nan || cls[1].is_nan))
        |-> ((&quot[WORD_W-2 -: EXP_W]) && quot[QBIT]));
endmodule

// File: tb/fdiv64_iter_bench.sv
`timescale 1ns/1ps
module fdiv64_iter_bench;
    localparam int LAT  = 58;
    localparam int NVEC = 26;

    // Operand pairs {A, B}; expected values come from the requirement model below
    localparam logic [127:0] VEC [NVEC] = '{
        {64'h3FF0000000000000, 64'h4000000000000000},
        {64'h400C000000000000, 64'h3FF8000000000000},
        {64'h3FF0000000000000, 64'h4008000000000000},
        {64'h400921FB54442D18, 64'h4005BF0A8B145769},
        {64'hBFF8000000000000, 64'h4024000000000000},
        {64'hC01C000000000000, 64'hBFB999999999999A},
        {64'h3FFFFFFFFFFFFFFF, 64'h3FF0000000000001},
        {64'h3FF0000000000000, 64'h3FEFFFFFFFFFFFFF},
        {64'h7FE0000000000000, 64'h3F10000000000000},
        {64'h0010000000000000, 64'h4000000000000000},
        {64'h7FF8000000000001, 64'h4000000000000000},
        {64'h4000000000000000, 64'h7FF0000000000005},
        {64'h7FF8000000000011, 64'hFFF8000000000022},
        {64'h7FF8000000000011, 64'h7FF0000000000005},
        {64'h0000000000000000, 64'h8000000000000000},
        {64'h7FF0000000000000, 64'hFFF0000000000000},
        {64'h4014000000000000, 64'h8000000000000000},
        {64'h8000000000000000, 64'hC008000000000000},
        {64'h0000000000000001, 64'h3FF0000000000000},
        {64'h3FF0000000000000, 64'h000FFFFFFFFFFFFF},
        {64'hFFF0000000000000, 64'h4000000000000000},
        {64'h4000000000000000, 64'hFFF0000000000000},
        {64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF},
        {64'h0010000000000000, 64'h3FEFFFFFFFFFFFFF},
        {64'h7FF0000000000001, 64'h7FF8000000000002},
        {64'h3FF0000000000000, 64'h4330000000000000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [63:0] opa, opb;
    logic        done;
    logic [63:0] quot;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    fdiv64_iter u_fdiv64_iter (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opa(opa), .opb(opb), .done(done), .quot(quot)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R3 watchdog actual=%0d cycles expected=done", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_nan(input logic [63:0] w);
        return (&w[62:52]) && (w[51:0] != 0);
    endfunction

    // Expected result from the requirements
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b);
        logic az, bz, ai, bi, aq, bq, as_, bs_, sg;
        logic [63:0] r;
        az = (a[62:52] == 0);  bz = (b[62:52] == 0);
        ai = (&a[62:52]) && (a[51:0] == 0);
        bi = (&b[62:52]) && (b[51:0] == 0);
        aq = is_nan(a) && a[51];  bq = is_nan(b) && b[51];
        as_ = is_nan(a) && !a[51]; bs_ = is_nan(b) && !b[51];
        sg = a[63] ^ b[63];
        if (as_) return a | (64'h1 << 51);
        if (bs_) return b | (64'h1 << 51);
        if (aq)  return a;
        if (bq)  return b;
        if ((az && bz) || (ai && bi)) return 64'h7FF8000000000000;
        if (ai || bz) return {sg, 11'h7FF, 52'h0};
        if (az || bi) return {sg, 63'h0};
        r = $realtobits($bitstoreal(a) / $bitstoreal(b));
        if (r[62:52] == 0) return {sg, 63'h0};
        return r;
    endfunction

    function automatic string tag_of(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        if ((is_nan(a) && !a[51]) || (is_nan(b) && !b[51])) return "R5";
        if (is_nan(a) || is_nan(b)) return "R6";
        if ((a[62:52] == 0 && a[51:0] != 0) || (b[62:52] == 0 && b[51:0] != 0)) return "R11";
        if ((a[62:52] == 0 && b[62:52] == 0) || (&a[62:52] && &b[62:52])) return "R7";
        if (&a[62:52] || b[62:52] == 0) return "R8";
        if (a[62:52] == 0 || &b[62:52]) return "R9";
        r = model(a, b);
        if (r[62:52] == 0 || &r[62:52]) return "R10";
        return "R2";
    endfunction

    // Issue one operation and wait for done; also reports pulse width and hold
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] res, output int lat, output bit pulse_ok);
        @(negedge clk);
        opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0; res = '0; pulse_ok = 1'b0;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (done) begin lat = n; res = quot; break; end
        end
        @(negedge clk);
        pulse_ok = !done && (quot == res);
    endtask

    initial begin
        logic [63:0] res, exp;
        int          lat, ndone;
        bit          pok;

        rst_n = 1'b0; start = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R12 reset done", {63'h0, done}, 64'h0);
        chk(quot == 64'h0, "R12 reset quot", quot, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            exp = model(VEC[i][127:64], VEC[i][63:0]);
            run_op(VEC[i][127:64], VEC[i][63:0], res, lat, pok);
            chk(res == exp, tag_of(VEC[i][127:64], VEC[i][63:0]), res, exp);
            chk(lat == LAT, "R3 latency", 64'(lat), 64'(LAT));
            chk(pok, "R3 single pulse and hold", res, exp);
            if (!is_nan(exp))
                chk(res[63] == (VEC[i][127] ^ VEC[i][63]), "R1 sign",
                    {63'h0, res[63]}, {63'h0, VEC[i][127] ^ VEC[i][63]});
        end

        // R4: a second start mid-flight is ignored
        @(negedge clk);
        opa = 64'h401C000000000000; opb = 64'h4000000000000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0; ndone = 0; lat = 0; res = '0;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (n == 10) begin
                opa = 64'h3FF0000000000000; opb = 64'h4008000000000000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                ndone++;
                if (ndone == 1) begin lat = n; res = quot; end
            end
        end
        chk(res == 64'h400C000000000000, "R4 result kept", res, 64'h400C000000000000);
        chk(lat == LAT, "R4 latency kept", 64'(lat), 64'(LAT));
        chk(ndone == 1, "R4 no extra done", 64'(ndone), 64'h1);

        // R12: reset mid-operation abandons it
        @(negedge clk);
        opa = 64'h4000000000000000; opb = 64'h4008000000000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && quot == 64'h0, "R12 mid-op reset", quot, 64'h0);
        rst_n = 1'b1;
        ndone = 0;
        for (int n = 0; n < 80; n++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk(ndone == 0, "R12 abandoned op", 64'(ndone), 64'h0);

        summary();
        $finish;
    end
endmodule